// File: doc/BRIEF.md
# Receive FIFO Periodic Flush Timer

This block sits beside a receive FIFO and watches the time that received frames may wait in it. A counter advances on a one-clock macrotick strobe. It is restarted at every communication-cycle start and again each time the programmed number of macroticks has passed. Each restart in the normal range is an expiry. If an expiry finds the FIFO holding frames while its fill level is still below the almost-full watermark, the block raises the almost-full interrupt anyway. Software then drains the frames instead of waiting for the watermark.

Two duration codes are reserved. A duration of zero keeps the timer expired in every clock. The all-ones code (0x3FFF for the 14-bit default) stops it from ever expiring. The duration is captured into an active copy at reset and at every restart, so a new value takes effect only from the next restart. The interrupt flag is sticky. It is also set through the ordinary watermark path whenever the fill level is at or above the watermark.

Top module: `rx_fifo_flush_timer`

## Requirements
- R1: A synchronous active-high reset clears the macrotick counter, `expired_o` and `irq_o`, and captures `dur_i` as the active duration.
- R2: With an active duration of 0, `expired_o` is 1 in every clock after the one in which that duration became active.
- R3: With an active duration of all ones (0x3FFF), `expired_o` stays 0 regardless of macroticks and cycle starts.
- R4: For an active duration d with 0 < d < 0x3FFF, `expired_o` pulses high for one clock. The pulse follows the clock edge that samples the d-th macrotick since the last restart, and the counter then restarts.
- R5: In the normal duration range, a cycle-start strobe is itself an expiry: `expired_o` is 1 on the next clock and the counter restarts at zero. A macrotick in the same clock as a cycle start is not counted.
- R6: An expiry sets `irq_o` on the next clock only when `fill_i` is nonzero and below `wmark_i`. An expiry with `fill_i` equal to 0 leaves `irq_o` unchanged.
- R7: Whenever `fill_i` is nonzero and at least `wmark_i`, `irq_o` is set on the next clock, independent of the timer.
- R8: `irq_o` stays set until `irq_clr_i` is high. A clear in a clock with no set condition drops `irq_o` on the next clock. A set condition in the same clock as a clear wins.
- R9: A change of `dur_i` has no effect on the running period. The new value becomes active at the next restart: a reset, a cycle start, or an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dur_i | input | DUR_W (14) | Programmed duration in macroticks; 0 and all-ones are reserved |
| mtick_i | input | 1 | One-clock macrotick strobe |
| cyc_start_i | input | 1 | One-clock communication-cycle-start strobe |
| fill_i | input | LVL_W (8) | Current FIFO fill level |
| wmark_i | input | LVL_W (8) | Almost-full watermark |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt flag |
| expired_o | output | 1 | Registered timer-expiry flag |
| irq_o | output | 1 | Sticky almost-full interrupt request |

## Verification
A counter that is off by one, or that is not cleared at a cycle start, shows on `expired_o` as a pulse one or more clocks early or late. The error is visible on the first expiry after the fault. An active-duration copy that reloads at the wrong moment breaks the period only after `dur_i` changes. For that reason the bench changes the duration in the middle of a period and checks both the old period and the new one. A wrong set condition or a wrong clear priority on the interrupt flag shows on `irq_o` one clock after the expiry, watermark or clear that triggers it. The bench model is compared on every clock, so these faults are caught in the clock where they first diverge.

// File: rtl/rxft_pkg.sv
package rxft_pkg;

  typedef enum logic [1:0] {
    MODE_ALWAYS = 2'd0,
    MODE_NEVER  = 2'd1,
    MODE_TIMED  = 2'd2
  } dur_mode_e;

  function automatic dur_mode_e classify_dur(input logic [31:0] dur, input int unsigned width);
    logic [31:0] all_ones;
    all_ones = (32'd1 << width) - 32'd1;
    if (dur == 32'd0)         return MODE_ALWAYS;
    else if (dur == all_ones) return MODE_NEVER;
    else                      return MODE_TIMED;
  endfunction

endpackage

// File: rtl/rxft_counter.sv
module rxft_counter
  import rxft_pkg::*;
#(
  parameter int DUR_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             mtick_i,
  input  logic             cyc_start_i,
  output logic             expire_o,
  output dur_mode_e        mode_o
);

  localparam logic [DUR_W-1:0] ONE = {{(DUR_W-1){1'b0}}, 1'b1};

  logic [DUR_W-1:0] act_dur_q;
  logic [DUR_W-1:0] cnt_q;
  logic             restart;
  logic             period_done;

  assign mode_o      = classify_dur(32'(act_dur_q), DUR_W);
  assign period_done = mtick_i && (cnt_q == act_dur_q - ONE);

  always_comb begin
    unique case (mode_o)
      MODE_ALWAYS: expire_o = 1'b1;
      MODE_NEVER:  expire_o = 1'b0;
      default:     expire_o = cyc_start_i || period_done;
    endcase
  end

  assign restart = cyc_start_i || expire_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      act_dur_q <= dur_i;
    end else if (restart) begin
      cnt_q     <= '0;
      act_dur_q <= dur_i;
    end else if (mtick_i && mode_o == MODE_TIMED) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  AST_CNT_BELOW_DUR: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_TIMED) |-> (cnt_q < act_dur_q)); // R4

  AST_CYC_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    cyc_start_i |=> (cnt_q == '0)); // R5

  AST_DUR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!cyc_start_i && !expire_o) |=> $stable(act_dur_q)); // R9

endmodule

// File: rtl/rxft_irq.sv
module rxft_irq #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire_i,
  input  logic [LVL_W-1:0] fill_i,
  input  logic [LVL_W-1:0] wmark_i,
  input  logic             clr_i,
  output logic             irq_o
);

  logic nonempty;
  logic at_wmark;
  logic timer_set;
  logic wmark_set;
  logic set_now;
  logic irq_q;

  assign nonempty  = (fill_i != '0);
  assign at_wmark  = (fill_i >= wmark_i);
  assign timer_set = expire_i && nonempty && !at_wmark;
  assign wmark_set = nonempty && at_wmark;
  assign set_now   = timer_set || wmark_set;

  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (set_now) irq_q <= 1'b1;
    else if (clr_i)   irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_i) |=> irq_q); // R8

  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !expire_i && !at_wmark) |=> !irq_q); // R8

  AST_EMPTY_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && fill_i == '0) |=> !irq_q); // R6

  AST_WMARK_SETS: assert property (@(posedge clk) disable iff (rst)
    (nonempty && at_wmark) |=> irq_q); // R7

endmodule

// File: rtl/rx_fifo_flush_timer.sv
module rx_fifo_flush_timer
  import rxft_pkg::*;
#(
  parameter int DUR_W = 14,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DUR_W-1:0] dur_i,
  input  logic             mtick_i,
  input  logic             cyc_start_i,
  input  logic [LVL_W-1:0] fill_i,
  input  logic [LVL_W-1:0] wmark_i,
  input  logic             irq_clr_i,
  output logic             expired_o,
  output logic             irq_o
);

  logic      expire;
  dur_mode_e mode;
  logic      expired_q;

  rxft_counter #(.DUR_W(DUR_W)) u_counter (
    .clk         (clk),
    .rst         (rst),
    .dur_i       (dur_i),
    .mtick_i     (mtick_i),
    .cyc_start_i (cyc_start_i),
    .expire_o    (expire),
    .mode_o      (mode)
  );

  rxft_irq #(.LVL_W(LVL_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .expire_i (expire),
    .fill_i   (fill_i),
    .wmark_i  (wmark_i),
    .clr_i    (irq_clr_i),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) expired_q <= 1'b0;
    else     expired_q <= expire;
  end

  assign expired_o = expired_q;

  AST_ZERO_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ALWAYS) |=> expired_o); // R2

  AST_ALLONES_NEVER: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_NEVER) |=> !expired_o); // R3

  AST_CYC_EXPIRES: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_TIMED && cyc_start_i) |=> expired_o); // R5

endmodule

// File: tb/rx_fifo_flush_timer_bench.sv
module rx_fifo_flush_timer_bench;

  localparam int DUR_W = 14;
  localparam int LVL_W = 8;
  localparam int NEVER = (1 << DUR_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DUR_W-1:0] dur = 14'd5;
  logic             mtick = 1'b0;
  logic             cyc = 1'b0;
  logic [LVL_W-1:0] fill = '0;
  logic [LVL_W-1:0] wm = 8'd4;
  logic             clr = 1'b0;
  logic             expired_o;
  logic             irq_o;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string req = "R1";

  // behavioural reference state
  int m_cnt = 0;
  int m_dur = 5;
  int m_exp = 0;
  int m_irq = 0;

  always #5 clk = ~clk;

  rx_fifo_flush_timer #(.DUR_W(DUR_W), .LVL_W(LVL_W)) u_rx_fifo_flush_timer (
    .clk(clk), .rst(rst), .dur_i(dur), .mtick_i(mtick), .cyc_start_i(cyc),
    .fill_i(fill), .wmark_i(wm), .irq_clr_i(clr),
    .expired_o(expired_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    int ev;
    int setc;
    int f;
    int w;
    f = int'(fill);
    w = int'(wm);
    if (rst) begin
      m_cnt = 0; m_dur = int'(dur); m_exp = 0; m_irq = 0;
    end else begin
      ev = 0;
      if (m_dur == 0) ev = 1;
      else if (m_dur == NEVER) ev = 0;
      else if (cyc) ev = 1;
      else if (mtick && (m_cnt + 1 == m_dur)) ev = 1;
      setc = ((ev != 0) && f != 0 && f < w) || (f != 0 && f >= w);
      if (cyc || ev != 0) begin
        m_cnt = 0;
        m_dur = int'(dur);
      end else if (mtick && m_dur != 0 && m_dur != NEVER) begin
        m_cnt = m_cnt + 1;
      end
      if (setc != 0) m_irq = 1;
      else if (clr) m_irq = 0;
      m_exp = ev;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (int'(expired_o) != m_exp) begin
      errors++;
      $display("FAIL %s expired_o actual=%0d expected=%0d t=%0t", req, expired_o, m_exp, $time);
    end
    checks++;
    if (int'(irq_o) != m_irq) begin
      errors++;
      $display("FAIL %s irq_o actual=%0d expected=%0d t=%0t", req, irq_o, m_irq, $time);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic mt, input logic cs, input logic cl);
    @(negedge clk);
    #1;
    mtick = mt; cyc = cs; clr = cl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0);
      step(0, 0, 0);
    end
  endtask

  initial begin
    int lfsr;
    // R1: reset state
    req = "R1";
    idle(3);
    rst = 0;
    // R4: timed expiry with dur 5, empty FIFO
    req = "R4";
    ticks(12);
    for (int i = 0; i < 11; i++) step(1, 0, 0);
    idle(2);
    // R5: cycle start mid-period and together with a macrotick
    req = "R5";
    ticks(2);
    step(0, 1, 0);
    ticks(3);
    step(1, 1, 0);
    ticks(6);
    // R6: timer expiry with frames below watermark sets the flag
    req = "R6";
    fill = 8'd2; wm = 8'd4;
    ticks(6);
    step(0, 0, 1);
    idle(2);
    fill = 8'd0;
    ticks(6);
    step(0, 1, 0);
    idle(2);
    // R7: watermark path with timer never expiring
    req = "R7";
    dur = 14'(NEVER);
    step(0, 1, 0);
    idle(2);
    fill = 8'd4;
    idle(3);
    // R8: clear loses to a live set, then wins
    req = "R8";
    step(0, 0, 1);
    idle(1);
    fill = 8'd1;
    step(0, 0, 1);
    idle(2);
    step(0, 0, 1);
    step(0, 0, 0);
    idle(2);
    // R3: all-ones never expires
    req = "R3";
    fill = 8'd0;
    ticks(30);
    step(0, 1, 0);
    ticks(10);
    // R2: zero keeps the timer expired; needs a restart to become active
    req = "R2";
    dur = 14'd0;
    idle(3);
    step(0, 1, 0);
    ticks(5);
    fill = 8'd3;
    idle(2);
    step(0, 0, 1);
    idle(2);
    fill = 8'd0;
    step(0, 0, 1);
    idle(2);
    // R9: duration change applies at next restart only
    req = "R9";
    dur = 14'd4;
    idle(2);
    ticks(8);
    ticks(2);
    dur = 14'd2;
    ticks(6);
    dur = 14'd7;
    step(0, 1, 0);
    ticks(9);
    // R1: mid-run reset
    req = "R1";
    fill = 8'd2;
    ticks(3);
    rst = 1;
    idle(2);
    rst = 0;
    fill = 8'd0;
    idle(2);
    // mixed stimulus against the model
    req = "R4";
    lfsr = 32'h1ACE;
    for (int i = 0; i < 2000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
      if ((lfsr & 32'h3F) == 0) dur = 14'((lfsr >> 6) & 15);
      if ((lfsr & 32'h1F0) == 0) fill = 8'((lfsr >> 9) & 7);
      step((lfsr & 2) != 0, ((lfsr >> 4) & 63) == 5, ((lfsr >> 10) & 7) == 1);
    end
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule